// File: doc/BRIEF.md
# Differential Lane Map Encoder

This block turns a board-level wiring description of a four-lane differential transmitter into the two compact values a pad multiplexer needs: a permutation index and a polarity mask. The wiring description lists, for each of the four transmit functions, the physical pins that carry its positive and negative legs. Each pin number is a 4-bit field, so pin numbers outside the legal range 0 to 7 can be expressed and must be rejected.

After a start pulse the block examines one pair per clock. For each legal pair it works out which physical lane the pair lands on and whether the legs are swapped. When all four pairs are accepted, it scans a fixed ordered list of 24 lane permutations, one entry per clock, until it finds the permutation that was recorded. A single-cycle done pulse then reports the result, together with an error flag for rejected wiring or a miss flag for a wiring that is legal pair by pair but is not a permutation.

Top module: `lane_map_enc`

## Requirements
- R1: While reset is held and after it is released, perm_idx, pol_mask, done, err and miss are all 0.
- R2: A pair in which either pin number is 8 or more is rejected and raises err.
- R3: A pair with an even positive pin must have its negative pin one higher and gives lane polarity 0; a pair with an odd positive pin must have its negative pin one lower and gives polarity 1; any other pair raises err.
- R4: An accepted pair k (k = 0..3, taken from pin_map bits 8k+3:8k for the positive pin and 8k+7:8k+4 for the negative pin) is carried on physical lane positive pin / 2, which records function k.
- R5: The recorded functions form a 16-bit word with lane 0 in bits 15:12 down to lane 3 in bits 3:0; perm_idx is the position of that word in the list 0123, 0132, 0312, 0321, 0231, 0213, 1023, 1032, 3012, 3021, 2031, 2013, 1203, 1302, 3102, 3201, 2301, 2103, 1230, 1320, 3120, 3210, 2310, 2130.
- R6: If the word is not in the list, perm_idx is 0 and miss is raised with done; pol_mask still reports the recorded polarities.
- R7: pol_mask bit 0 holds lane 0 polarity, bit 3 lane 1, bit 2 lane 2 and bit 1 lane 3.
- R8: On the first rejected pair the block stops, pulses done with err set, and leaves perm_idx and pol_mask at 0; err and miss are never both set.
- R9: Counting the edge that samples start as edge 0, done rises after edge 5 + perm_idx on a hit, after edge 28 on a miss, and after edge k + 1 when pair k is rejected.
- R10: done is high for exactly one cycle per accepted start, and start is ignored while a run is in progress.
- R11: Each accepted start clears the results and flags and resets every lane record to function 0, polarity 0 before the pairs are examined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| pin_map | input | 32 | Four pairs, one byte per function: positive pin low nibble, negative pin high nibble |
| perm_idx | output | 5 | Position of the lane permutation in the fixed list |
| pol_mask | output | 4 | Per-lane swap flags in the bit order of R7 |
| done | output | 1 | One-cycle pulse when the result is ready |
| err | output | 1 | Wiring rejected; held until the next start |
| miss | output | 1 | Permutation not found; held until the next start |

## Verification
The properties assume that start is only acted on when the block is idle and that pin_map stays steady while pairs are being examined, since each pair is read directly from the input on its own cycle. The stimulus sets pin_map before raising start and keeps it unchanged until done, except in the one directed case that pulses start mid-run with a different map, which checks that the extra start is ignored, not that the map may change. The vectors cover hits at the first, middle and last list positions, all three rejection kinds at different pair positions, and a lane collision that reaches the end of the list.

// File: rtl/lane_map_pkg.sv
package lane_map_pkg;

  localparam int NUM_LANES = 4;
  localparam int PIN_W     = 4;
  localparam int LIST_LEN  = 24;
  localparam int IDX_W     = $clog2(LIST_LEN);
  localparam int LANE_W    = $clog2(NUM_LANES);
  localparam int NIB_W     = 4;
  localparam int WORD_W    = NUM_LANES * NIB_W;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CHECK  = 2'd1,
    PH_SEARCH = 2'd2
  } phase_t;

  // Ordered permutation list; position in this list is the output code.
  function automatic logic [WORD_W-1:0] perm_entry(input logic [IDX_W-1:0] pos);
    case (pos)
      5'd0:  return 16'h0123;
      5'd1:  return 16'h0132;
      5'd2:  return 16'h0312;
      5'd3:  return 16'h0321;
      5'd4:  return 16'h0231;
      5'd5:  return 16'h0213;
      5'd6:  return 16'h1023;
      5'd7:  return 16'h1032;
      5'd8:  return 16'h3012;
      5'd9:  return 16'h3021;
      5'd10: return 16'h2031;
      5'd11: return 16'h2013;
      5'd12: return 16'h1203;
      5'd13: return 16'h1302;
      5'd14: return 16'h3102;
      5'd15: return 16'h3201;
      5'd16: return 16'h2301;
      5'd17: return 16'h2103;
      5'd18: return 16'h1230;
      5'd19: return 16'h1320;
      5'd20: return 16'h3120;
      5'd21: return 16'h3210;
      5'd22: return 16'h2310;
      5'd23: return 16'h2130;
      default: return 16'hFFFF;
    endcase
  endfunction

  // Lane polarity vector (bit i = lane i) to output mask order.
  function automatic logic [3:0] pol_pack(input logic [3:0] lane_pol);
    return {lane_pol[1], lane_pol[2], lane_pol[3], lane_pol[0]};
  endfunction

endpackage

// File: rtl/lane_pair_check.sv
module lane_pair_check #(
  parameter int PIN_W  = 4,
  parameter int N_PINS = 8,
  parameter int LANE_W = 2
) (
  input  logic [PIN_W-1:0]  pos_pin,
  input  logic [PIN_W-1:0]  neg_pin,
  output logic              pair_ok,
  output logic [LANE_W-1:0] lane,
  output logic              swapped
);
  logic             in_range;
  logic [PIN_W-1:0] partner;

  always_comb begin
    in_range = (int'(pos_pin) < N_PINS) && (int'(neg_pin) < N_PINS);
    swapped  = pos_pin[0];
    partner  = pos_pin[0] ? (pos_pin - PIN_W'(1)) : (pos_pin + PIN_W'(1));
    pair_ok  = in_range && (neg_pin == partner);
    lane     = pos_pin[LANE_W:1];
  end
endmodule

// File: rtl/lane_func_store.sv
module lane_func_store #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 2,
  parameter int NIB_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       wr_en,
  input  logic [LANE_W-1:0]          wr_lane,
  input  logic [LANE_W-1:0]          wr_func,
  input  logic                       wr_pol,
  output logic [NUM_LANES*NIB_W-1:0] perm_word,
  output logic [NUM_LANES-1:0]       lane_pol
);
  localparam int WORD_W = NUM_LANES * NIB_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] func_q;
    logic              pol_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        func_q <= '0;
        pol_q  <= 1'b0;
      end else if (wr_en && (wr_lane == LANE_W'(g))) begin
        func_q <= wr_func;
        pol_q  <= wr_pol;
      end
    end

    assign perm_word[WORD_W-1-g*NIB_W -: NIB_W] = {{(NIB_W-LANE_W){1'b0}}, func_q};
    assign lane_pol[g] = pol_q;
  end
endmodule

// File: rtl/lane_perm_search.sv
module lane_perm_search
  import lane_map_pkg::*;
#(
  parameter int LIST_N = 24,
  parameter int POS_W  = 5,
  parameter int WRD_W  = 16
) (
  input  logic [POS_W-1:0] scan_pos,
  input  logic [WRD_W-1:0] perm_word,
  output logic             hit,
  output logic             at_end
);
  always_comb begin
    hit    = (perm_entry(scan_pos) == perm_word);
    at_end = (scan_pos == POS_W'(LIST_N - 1));
  end
endmodule

// File: rtl/lane_map_enc.sv
module lane_map_enc
  import lane_map_pkg::*;
#(
  parameter int LANES = NUM_LANES,
  parameter int PW    = PIN_W,
  parameter int LLEN  = LIST_LEN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [2*PW*LANES-1:0]   pin_map,
  output logic [$clog2(LLEN)-1:0] perm_idx,
  output logic [3:0]              pol_mask,
  output logic                    done,
  output logic                    err,
  output logic                    miss
);
  localparam int PAIR_W = 2 * PW;
  localparam int LW     = $clog2(LANES);
  localparam int IW     = $clog2(LLEN);
  localparam int WW     = LANES * NIB_W;

  phase_t          phase;
  logic [LW-1:0]   pair_sel;
  logic [IW-1:0]   scan_pos;
  logic [PW-1:0]   cur_pos, cur_neg;
  logic            pair_ok, pair_swap, last_pair;
  logic [LW-1:0]   pair_lane;
  logic [WW-1:0]   perm_word;
  logic [LANES-1:0] lane_pol;
  logic            list_hit, list_end;
  logic            busy, launch, pair_write;

  logic [IW-1:0]   idx_q;
  logic [3:0]      pol_q;
  logic            done_q, err_q, miss_q;

  assign busy       = (phase != PH_IDLE);
  assign launch     = (phase == PH_IDLE) && start;
  assign pair_write = (phase == PH_CHECK) && pair_ok;
  assign last_pair  = (pair_sel == LW'(LANES - 1));

  always_comb begin
    cur_pos = pin_map[pair_sel*PAIR_W +: PW];
    cur_neg = pin_map[pair_sel*PAIR_W + PW +: PW];
  end

  lane_pair_check #(.PIN_W(PW), .N_PINS(2*LANES), .LANE_W(LW)) u_check (
    .pos_pin (cur_pos),
    .neg_pin (cur_neg),
    .pair_ok (pair_ok),
    .lane    (pair_lane),
    .swapped (pair_swap)
  );

  lane_func_store #(.NUM_LANES(LANES), .LANE_W(LW), .NIB_W(NIB_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .wr_en     (pair_write),
    .wr_lane   (pair_lane),
    .wr_func   (pair_sel),
    .wr_pol    (pair_swap),
    .perm_word (perm_word),
    .lane_pol  (lane_pol)
  );

  lane_perm_search #(.LIST_N(LLEN), .POS_W(IW), .WRD_W(WW)) u_search (
    .scan_pos  (scan_pos),
    .perm_word (perm_word),
    .hit       (list_hit),
    .at_end    (list_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      pair_sel <= '0;
      scan_pos <= '0;
      idx_q    <= '0;
      pol_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      miss_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_CHECK;
            pair_sel <= '0;
            idx_q    <= '0;
            pol_q    <= '0;
            err_q    <= 1'b0;
            miss_q   <= 1'b0;
          end
        end
        PH_CHECK: begin
          if (!pair_ok) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            phase  <= PH_IDLE;
          end else if (last_pair) begin
            scan_pos <= '0;
            phase    <= PH_SEARCH;
          end else begin
            pair_sel <= pair_sel + LW'(1);
          end
        end
        PH_SEARCH: begin
          if (list_hit) begin
            idx_q  <= scan_pos;
            pol_q  <= pol_pack(lane_pol[3:0]);
            done_q <= 1'b1;
            phase  <= PH_IDLE;
          end else if (list_end) begin
            idx_q  <= '0;
            pol_q  <= pol_pack(lane_pol[3:0]);
            miss_q <= 1'b1;
            done_q <= 1'b1;
            phase  <= PH_IDLE;
          end else begin
            scan_pos <= scan_pos + IW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign perm_idx = idx_q;
  assign pol_mask = pol_q;
  assign done     = done_q;
  assign err      = err_q;
  assign miss     = miss_q;
endmodule

// File: rtl/lane_map_enc_chk.sv
module lane_map_enc_chk #(
  parameter int IW   = 5,
  parameter int LLEN = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          miss,
  input logic [IW-1:0] perm_idx,
  input logic [3:0]    pol_mask
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  a_r10_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r8_err_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (perm_idx == '0 && pol_mask == 4'd0));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && miss));

  a_r6_miss_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && miss) |-> perm_idx == '0);

  a_r5_idx_in_list: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(perm_idx) < LLEN));

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!done && !err && !miss && perm_idx == '0 && pol_mask == 4'd0));
endmodule

bind lane_map_enc lane_map_enc_chk #(.IW(IW), .LLEN(LLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .miss     (miss),
  .perm_idx (perm_idx),
  .pol_mask (pol_mask)
);

// File: tb/lane_map_enc_bench.sv
module lane_map_enc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pin_map = '0;
  logic [4:0]  perm_idx;
  logic [3:0]  pol_mask;
  logic        done, err, miss;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  lane_map_enc u_lane_map_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .pin_map(pin_map),
    .perm_idx(perm_idx), .pol_mask(pol_mask), .done(done), .err(err), .miss(miss)
  );

  // {map, idx, pol, err, miss, latency}
  localparam int NV = 13;
  localparam logic [48:0] VEC [NV] = '{
    {32'h76543210, 5'd0,  4'h0, 1'b0, 1'b0, 6'd6},   // R4 R5 identity
    {32'h67452301, 5'd0,  4'hF, 1'b0, 1'b0, 6'd6},   // R3 R7 all swapped
    {32'h10325476, 5'd21, 4'h0, 1'b0, 1'b0, 6'd27},  // R5 reversed
    {32'h54671023, 5'd7,  4'hA, 1'b0, 1'b0, 6'd13},  // R7 lanes 1,3 swapped
    {32'h76231045, 5'd12, 4'hC, 1'b0, 1'b0, 6'd18},  // R7 lanes 1,2 swapped
    {32'h45103267, 5'd23, 4'h6, 1'b0, 1'b0, 6'd29},  // R9 last entry
    {32'h76544210, 5'd0,  4'h0, 1'b1, 1'b0, 6'd3},   // R3 non-adjacent pair 1
    {32'h76543298, 5'd0,  4'h0, 1'b1, 1'b0, 6'd2},   // R2 pin 8 in pair 0
    {32'h76543287, 5'd0,  4'h0, 1'b1, 1'b0, 6'd2},   // R2 negative pin 8
    {32'h43543210, 5'd0,  4'h0, 1'b1, 1'b0, 6'd5},   // R3 odd pin going up, pair 3
    {32'h76213210, 5'd0,  4'h0, 1'b1, 1'b0, 6'd4},   // R3 odd pin going up, pair 2
    {32'h01101010, 5'd0,  4'h1, 1'b0, 1'b1, 6'd29},  // R6 lane collision
    {32'h76543210, 5'd0,  4'h0, 1'b0, 1'b0, 6'd6}    // R11 clean after miss
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Launch one run; returns edges from the start-sampling edge until done is seen.
  task automatic run(input logic [31:0] m, output int lat);
    @(negedge clk);
    pin_map = m;
    start   = 1'b1;
    lat     = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check(perm_idx == 0 && pol_mask == 0 && !done && !err && !miss, "R1 reset state",
          {perm_idx, pol_mask, done, err, miss}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(perm_idx == 0 && pol_mask == 0 && !done && !err && !miss, "R1 after release",
          {perm_idx, pol_mask, done, err, miss}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [48:0] e;
      e = VEC[v];
      run(e[48:17], lat);
      check(done, "R9 done seen", done, 1);
      check(lat == int'(e[5:0]), "R9 latency", lat, e[5:0]);
      check(perm_idx == e[16:12], "R5 index", perm_idx, e[16:12]);
      check(pol_mask == e[11:8], "R7 polarity", pol_mask, e[11:8]);
      check(err == e[7], "R8 err flag", err, e[7]);
      check(miss == e[6], "R6 miss flag", miss, e[6]);
      @(negedge clk);
      check(!done, "R10 single-cycle done", done, 0);
    end

    // R11: flags clear on a new start (err left over from a rejected run)
    run(32'h76543298, lat);
    check(err, "R11 err set before restart", err, 1);
    @(negedge clk);
    pin_map = 32'h76543210;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!err && !miss && perm_idx == 0, "R11 flags cleared on start", {err, miss}, 0);
    repeat (8) @(negedge clk);

    // R10: start pulsed mid-run with another map is ignored
    begin
      int extra;
      extra = 0;
      @(negedge clk);
      pin_map = 32'h10325476;
      start = 1'b1;
      lat = 0;
      for (int i = 0; i < 60; i++) begin
        @(posedge clk);
        lat++;
        @(negedge clk);
        start = (lat == 10);
        if (done) break;
      end
      start = 1'b0;
      check(lat == 27, "R10 restart ignored latency", lat, 27);
      check(perm_idx == 21, "R10 restart ignored index", perm_idx, 21);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R10 no second done", extra, 0);
    end

    // R1: reset in the middle of a run
    @(negedge clk);
    pin_map = 32'h67452301;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check(seen == 0 && pol_mask == 0 && perm_idx == 0, "R1 reset aborts run", seen, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule